// File: doc/BRIEF.md
# Four-Bank Interleaved Line Memory Controller

This block sits below a cache and serves two kinds of request against four word-wide memory banks that share a one-word return bus. A line read sends its address to all four banks in a single cycle. The banks then work in parallel for a fixed access latency, and the four words of the line come back over the bus, one word per cycle, in ascending order. A word write goes to the single bank that owns that word. Writes to different banks can be taken one per cycle. A write to a bank that is still working on an earlier access is held off.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold the request steady while `req_ready` is low. `req_ready` is computed combinationally from the request that is being offered: its type and, for a write, its bank. It therefore changes when the offered request changes. The response has no back-pressure. Each beat appears for exactly one cycle, and the requester must capture it.

The banks are behavioural arrays with a fixed latency. The word address is split as follows: the two low bits select the bank, and the bits above them select the row inside that bank.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `rsp_valid` is 0 and `req_ready` is 1 for both a read and a write request.
- R2: A read request (`req_write`=0) returns the line that contains `req_addr`, and bits [1:0] of `req_addr` are ignored. Beat b carries the word last written at word address {line, b}.
- R3: If a read is taken at clock edge k, its beats are visible on `rsp_data` in the cycles that follow edges k+10, k+11, k+12 and k+13, and `rsp_valid` is 0 from edge k up to edge k+10. Counting the request cycle, a line read takes 15 cycles.
- R4: The four beats of a read are consecutive and in ascending word order. `rsp_last` is 1 only on the fourth beat, and never while `rsp_valid` is 0.
- R5: Bits [1:0] of a write address select the bank. A bank is busy for 10 cycles after it takes an access, so a write to the same bank as a write taken at edge k is taken no earlier than edge k+10. `req_ready` is 0 for that write until then.
- R6: Writes to banks that are idle are taken one per cycle, so four writes to consecutive word addresses are taken on four consecutive edges.
- R7: From the edge that takes a read until the edge that transfers its last beat, `req_ready` is 0 for every request. If a request is held waiting, it is taken 15 edges after the read was taken.
- R8: A read is taken only when all four banks are idle. A read held behind a write taken at edge k is therefore taken at edge k+10 at the earliest.
- R9: While some banks are busy and no read is in flight, `req_ready` depends on the offered request: it is 1 for a write to an idle bank and 0 for a write to a busy bank or for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken at this edge |
| req_write | input | 1 | 1 = word write, 0 = line read |
| req_addr | input | ADDR_W | Word address; bits [1:0] select the bank |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | A read beat is on `rsp_data` |
| rsp_last | output | 1 | This is the fourth beat of the line |
| rsp_data | output | DATA_W | Read beat data |

## Verification
The bench writes every word of a small memory in address order. The fifth write of each group lands on a bank that is still busy. A design that miscounts the busy window would take that write one cycle early or one cycle late, and one that serialises all writes would fall behind from the second write onwards. Every line is then read back to back, including lines addressed with nonzero low bits. This checks the exact cycle of each beat, the word order, the single-cycle `rsp_last` and the 15-cycle spacing between reads, so an off-by-one in the latency timer or a bank index taken from the address instead of the beat count shows up at once. The last cases cover ordering across request types: a write held behind an in-flight read, a read held behind a busy bank, and the dependence of `req_ready` on the offered request. A design that lets a read start early would return stale data.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Kind of request carried by the handshake.
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/ilv_bank.sv
// One word-wide bank: storage, a busy counter and a read latch.
module ilv_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 4,
  parameter int LAT    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CW    = $clog2(LAT + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;

  // The counter is loaded with LAT-1, so the bank is unavailable for LAT edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (rd_go || wr_go) begin
      cnt <= CW'(LAT - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      mem[row] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_go) begin
      rdata <= mem[row];
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ilv_rd_seq.sv
// Read sequencer: waits out the access latency, then walks the beats.
module ilv_rd_seq #(
  parameter int LAT   = 10,
  parameter int NBANK = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     pend,
  output logic                     beat_valid,
  output logic                     beat_last,
  output logic [$clog2(NBANK)-1:0] beat_idx
);
  localparam int TW = $clog2(LAT + 1);
  localparam int BW = $clog2(NBANK);

  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      timer    <= '0;
      beat_idx <= '0;
    end else if (start) begin
      pend     <= 1'b1;
      timer    <= TW'(LAT);
      beat_idx <= '0;
    end else if (pend) begin
      if (timer != '0) begin
        timer <= timer - TW'(1);
      end else begin
        beat_idx <= beat_idx + BW'(1);
        if (beat_idx == BW'(NBANK - 1)) begin
          pend <= 1'b0;
        end
      end
    end
  end

  assign beat_valid = pend && (timer == '0);
  assign beat_last  = beat_valid && (beat_idx == BW'(NBANK - 1));
endmodule

// File: rtl/ilv_mem_ctrl.sv
// Interleaved line memory controller: NBANK word-wide banks, one shared bus.
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LAT    = 10,
  parameter int NBANK  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_last,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int BSEL_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BSEL_W;

  op_e                req_op;
  logic [BSEL_W-1:0]  bank_sel;
  logic [ROW_W-1:0]   row_sel;
  logic [NBANK-1:0]   busy;
  logic [DATA_W-1:0]  bank_q [NBANK];
  logic               rd_pend;
  logic               fire;
  logic [BSEL_W-1:0]  beat_idx;

  assign req_op   = req_write ? OP_WRITE : OP_READ;
  assign bank_sel = req_addr[BSEL_W-1:0];
  assign row_sel  = req_addr[ADDR_W-1:BSEL_W];

  // A write needs only its own bank; a read needs all banks and the bus.
  always_comb begin
    if (rd_pend) begin
      req_ready = 1'b0;
    end else if (req_op == OP_WRITE) begin
      req_ready = !busy[bank_sel];
    end else begin
      req_ready = (busy == '0);
    end
  end

  assign fire = req_valid && req_ready;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    ilv_bank #(
      .DATA_W(DATA_W),
      .ROW_W (ROW_W),
      .LAT   (LAT)
    ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_go(fire && (req_op == OP_READ)),
      .wr_go(fire && (req_op == OP_WRITE) && (bank_sel == BSEL_W'(g))),
      .row  (row_sel),
      .wdata(req_wdata),
      .busy (busy[g]),
      .rdata(bank_q[g])
    );
  end

  ilv_rd_seq #(
    .LAT  (LAT),
    .NBANK(NBANK)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fire && (req_op == OP_READ)),
    .pend      (rd_pend),
    .beat_valid(rsp_valid),
    .beat_last (rsp_last),
    .beat_idx  (beat_idx)
  );

  assign rsp_data = bank_q[beat_idx];
endmodule

// File: rtl/ilv_mem_ctrl_chk.sv
// Protocol and timing checker bound to the controller.
module ilv_mem_ctrl_chk #(
  parameter int BSEL_W = 2,
  parameter int LAT    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [BSEL_W-1:0] bsel,
  input logic              rsp_valid,
  input logic              rsp_last
);
  localparam int SW = $clog2(LAT + 2) + 1;

  logic          rd_fire;
  logic          wr_fire;
  logic          armed;
  logic [SW-1:0] since_rd;

  assign rd_fire = req_valid && req_ready && !req_write;
  assign wr_fire = req_valid && req_ready && req_write;

  // Cycles since the last accepted read, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      since_rd <= '0;
    end else if (rd_fire) begin
      armed    <= 1'b1;
      since_rd <= '0;
    end else if (armed && since_rd != '1) begin
      since_rd <= since_rd + SW'(1);
    end
  end

  // R4: last flag only travels with a valid beat
  p_last_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  // R4: beats of a line are contiguous
  p_beats_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> rsp_valid);

  // R5: a bank cannot take a second write on the following edge
  p_same_bank_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !(req_valid && req_ready && req_write && bsel == $past(bsel)));

  // R7: nothing is accepted while a read is on the bus
  p_no_accept_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3: the first beat appears exactly LAT edges after the read was taken
  p_first_beat_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (armed && since_rd == SW'(LAT)));
endmodule

bind ilv_mem_ctrl ilv_mem_ctrl_chk #(
  .BSEL_W(BSEL_W),
  .LAT   (LAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .bsel     (req_addr[BSEL_W-1:0]),
  .rsp_valid(rsp_valid),
  .rsp_last (rsp_last)
);

// File: tb/ilv_mem_ctrl_tb.sv
module ilv_mem_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LAT    = 10;
  localparam int NWORDS = 1 << ADDR_W;
  localparam int NLINES = NWORDS / 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic              rsp_last;
  logic [DATA_W-1:0] rsp_data;

  ilv_mem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .NBANK(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int a);
    return 32'hC0DE0000 ^ DATA_W'(a * 37 + 5);
  endfunction

  // Offer a request at the current falling edge; return the accepting edge.
  task automatic issue(input bit wr, input int addr, input logic [DATA_W-1:0] d, output int acc);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(addr);
    req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    acc = cyc + 1;
    @(negedge clk);
  endtask

  // Watch one read taken at the previous edge; the next request is already offered.
  task automatic watch_line(input int line, input logic [DATA_W-1:0] w2);
    for (int j = 0; j < 14; j++) begin
      #1;
      chk(rsp_valid == (j >= LAT), "R3 beat timing", 64'(rsp_valid), 64'(j >= LAT));
      if (j >= LAT) begin
        chk(rsp_data == ((j - LAT == 2) ? w2 : pat(line * 4 + j - LAT)),
            "R2 R4 beat data", 64'(rsp_data),
            64'((j - LAT == 2) ? w2 : pat(line * 4 + j - LAT)));
      end
      chk(rsp_last == (j == LAT + 3), "R4 last flag", 64'(rsp_last), 64'(j == LAT + 3));
      chk(req_ready == 1'b0, "R7 ready during read", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int acc, first, last_wr, prev, wacc;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready for read", 64'(req_ready), 64'd1);
    req_write = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready for write", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    @(negedge clk);

    // Write sweep: rotating banks, fifth write of each group hits a busy bank.
    first = 0;
    for (int n = 0; n < NWORDS; n++) begin
      if (n > 0 && n % 4 == 0) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(n); req_wdata = pat(n);
        #1;
        chk(req_ready == 1'b0, "R5 ready low for busy bank", 64'(req_ready), 64'd0);
      end
      issue(1'b1, n, pat(n), acc);
      if (n == 0) first = acc;
      chk(acc - first == LAT * (n / 4) + (n % 4), (n % 4 == 0) ? "R5 same-bank stall" : "R6 one per cycle",
          64'(acc - first), 64'(LAT * (n / 4) + (n % 4)));
    end
    last_wr = acc;

    // Read every line back to back; some addresses carry nonzero low bits.
    prev = 0;
    for (int l = 0; l < NLINES; l++) begin
      issue(1'b0, l * 4 + ((l == 5) ? 3 : (l == 9) ? 1 : 0), '0, acc);
      if (l == 0) chk(acc == last_wr + LAT, "R8 read waits for banks", 64'(acc), 64'(last_wr + LAT));
      else chk(acc - prev == 15, "R7 read spacing", 64'(acc - prev), 64'd15);
      prev = acc;
      req_valid = 1'b1;
      if (l < NLINES - 1) begin
        req_write = 1'b0; req_addr = ADDR_W'((l + 1) * 4);
      end else begin
        req_write = 1'b1; req_addr = ADDR_W'(2); req_wdata = 32'h5A5A1234;
      end
      watch_line(l, pat(l * 4 + 2));
    end

    // Write held behind the last read, then probe ready per request kind.
    issue(1'b1, 2, 32'h5A5A1234, wacc);
    chk(wacc - prev == 15, "R7 write held behind read", 64'(wacc - prev), 64'd15);
    req_write = 1'b1; req_addr = ADDR_W'(1);
    #1;
    chk(req_ready == 1'b1, "R9 write to idle bank", 64'(req_ready), 64'd1);
    req_addr = ADDR_W'(6);
    #1;
    chk(req_ready == 1'b0, "R9 write to busy bank", 64'(req_ready), 64'd0);
    req_write = 1'b0; req_addr = ADDR_W'(0);
    #1;
    chk(req_ready == 1'b0, "R9 read with a busy bank", 64'(req_ready), 64'd0);

    // Read behind the busy bank returns the new word.
    issue(1'b0, 0, '0, acc);
    chk(acc == wacc + LAT, "R8 read behind write", 64'(acc), 64'(wacc + LAT));
    req_valid = 1'b0;
    watch_line_idle(32'h5A5A1234);
    summary();
    $finish;
  end

  task automatic watch_line_idle(input logic [DATA_W-1:0] w2);
    for (int j = 0; j < 14; j++) begin
      #1;
      chk(rsp_valid == (j >= LAT), "R3 beat timing", 64'(rsp_valid), 64'(j >= LAT));
      if (j >= LAT) begin
        chk(rsp_data == ((j - LAT == 2) ? w2 : pat(j - LAT)), "R2 rewritten word", 64'(rsp_data),
            64'((j - LAT == 2) ? w2 : pat(j - LAT)));
      end
      chk(rsp_last == (j == LAT + 3), "R4 last flag", 64'(rsp_last), 64'(j == LAT + 3));
      @(negedge clk);
    end
  endtask
endmodule